// File: doc/BRIEF.md
# Byte-wide serial port register front end

This block is the processor-facing register file of a simple serial port, laid out like the classic eight-register character UART. A small slave port carries a byte offset, separate read and write strobes and 8-bit data. Read data is combinational on the offset. Any side effect of a read happens on the clock edge that ends the read strobe.

Characters leave through a parallel valid/ready handshake and arrive through a one-cycle valid strobe. There is no serial shifter. A separate input injects a break condition. A single level interrupt reports two causes in fixed priority: received data first, then transmitter holding empty. Both causes are derived from registered state, so the interrupt follows every access on the next cycle.

The 16-bit baud divisor is stored and read back but never used. The FIFO-enabled flag seen in the interrupt identification byte is a build-time option; writes to the FIFO control offset are dropped.

Top module: `uart_regfront`

## Requirements
- R1: Only bits 2:0 of `bus_addr` choose among eight byte registers. Higher address bits have no effect.
- R2: After reset, offsets 0, 1, 3, 4, 6 and 7 read 0x00, offset 2 reads 0x01, offset 5 reads 0x60, and `irq` and `tx_valid` are low.
- R3: While line control (offset 3) bit 7 is 1, offsets 0 and 1 access the low and high byte of a 16-bit divisor. Such writes start no transmission and leave the interrupt enable byte unchanged.
- R4: The identification byte (offset 2) is 0x04 when status bit 0 (data ready) and enable bit 0 are both 1. Otherwise it is 0x02 when status bit 5 (holding empty) and enable bit 1 are both 1. Otherwise it is 0x01.
- R5: `irq` is high exactly when the identification code differs from 0x01.
- R6: Reading offset 0 with line control bit 7 clear returns the receive byte and then clears status bits 0 and 4.
- R7: Writing offset 0 with line control bit 7 clear raises `tx_valid` with the byte on the next cycle and clears status bits 5 and 6. The byte is held stable until `tx_ready` is sampled high. Both status bits return to 1 on the cycle after that handshake. A data write while a byte is still pending is dropped.
- R8: A `rx_valid` strobe loads the receive byte and sets status bit 0. If bit 0 was already set and no data read happens in the same cycle, status bit 1 (overrun) is set. Reading offset 5 clears bit 1. A data read in the same cycle as a strobe leaves bit 0 set.
- R9: `brk_inject` loads the receive byte with 0 and sets status bits 4 and 0.
- R10: When the parameter `FIFO_FLAG` is 1, a read of offset 2 returns the identification code with bits 7:6 set.
- R11: Writes to offsets 2 and 5 change nothing. Offsets 3, 4, 6 and 7 store any written byte and return it on read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register offset; low three bits decoded |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; side effects on its clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset |
| tx_data | output | 8 | Byte offered to the transmitter |
| tx_valid | output | 1 | Byte pending |
| tx_ready | input | 1 | Transmitter takes the pending byte |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle strobe for `rx_data` |
| brk_inject | input | 1 | Break condition strobe |
| irq | output | 1 | Level interrupt |

## Verification
The inline properties check, on every cycle, the following behaviour:
- the pending transmit byte holds until it is accepted and then drops;
- divisor-mode writes start no transmission;
- break and overrun set their status bits;
- a data read clears data-ready;
- the interrupt stays low when both enables are clear, or while a byte is pending and no data is waiting.

Only the bench's scenarios show the rest. That covers the exact read-back values of all eight offsets in both latch modes, the priority order of the identification code, the drop of a second transmit write, a data read that coincides with a receive strobe, and the build-time FIFO flag.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      OFS_DATA    = 3'd0,
      OFS_IEN     = 3'd1,
      OFS_IID     = 3'd2,
      OFS_LCTL    = 3'd3,
      OFS_MCTL    = 3'd4,
      OFS_LSTAT   = 3'd5,
      OFS_MSTAT   = 3'd6,
      OFS_SCRATCH = 3'd7
   } reg_ofs_e;

   // bit positions that software decodes
   localparam int LC_DLAB = 7;
   localparam int ST_DR   = 0;
   localparam int ST_OE   = 1;
   localparam int ST_BI   = 4;
   localparam int ST_THRE = 5;
   localparam int ST_TEMT = 6;
   localparam int IE_RX   = 0;
   localparam int IE_TX   = 1;

   localparam logic [BYTE_W-1:0] ID_NONE = 8'h01;
   localparam logic [BYTE_W-1:0] ID_TX   = 8'h02;
   localparam logic [BYTE_W-1:0] ID_RX   = 8'h04;
   localparam logic [BYTE_W-1:0] ID_FIFO = 8'hC0;

   // fixed priority: receive data ahead of holding-empty
   function automatic logic [BYTE_W-1:0] pick_iid(input logic rx_hit, input logic tx_hit);
      if (rx_hit)      return ID_RX;
      else if (tx_hit) return ID_TX;
      else             return ID_NONE;
   endfunction

endpackage

// File: rtl/uart_rf_txhold.sv
module uart_rf_txhold
   import uart_regfront_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [BYTE_W-1:0] byte_i,
   output logic [BYTE_W-1:0] tx_data_o,
   output logic              tx_valid_o,
   input  logic              tx_ready_i
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_valid_o <= 1'b0;
         tx_data_o  <= '0;
      end else if (tx_valid_o && tx_ready_i) begin
         tx_valid_o <= 1'b0;
      end else if (load_i && !tx_valid_o) begin
         tx_valid_o <= 1'b1;
         tx_data_o  <= byte_i;
      end
   end

   // R7: pending byte is frozen until the handshake
   a_r7_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

   // R7: accepted byte is released
   a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && tx_ready_i) |=> !tx_valid_o);

endmodule

// File: rtl/uart_rf_rxstat.sv
module uart_rf_rxstat
   import uart_regfront_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid_i,
   input  logic [BYTE_W-1:0] rx_byte_i,
   input  logic              brk_i,
   input  logic              take_i,
   input  logic              lsr_rd_i,
   output logic [BYTE_W-1:0] rbr_o,
   output logic              dr_o,
   output logic              bi_o,
   output logic              oe_o
);

   logic lost;
   assign lost = rx_valid_i && !brk_i && dr_o && !take_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbr_o <= '0;
         dr_o  <= 1'b0;
         bi_o  <= 1'b0;
         oe_o  <= 1'b0;
      end else begin
         if (brk_i) begin
            rbr_o <= '0;
            dr_o  <= 1'b1;
            bi_o  <= 1'b1;
         end else if (rx_valid_i) begin
            rbr_o <= rx_byte_i;
            dr_o  <= 1'b1;
            if (take_i) bi_o <= 1'b0;
         end else if (take_i) begin
            dr_o  <= 1'b0;
            bi_o  <= 1'b0;
         end
         if (lost)          oe_o <= 1'b1;
         else if (lsr_rd_i) oe_o <= 1'b0;
      end
   end

   // R8: a second byte over an unread one flags overrun
   a_r8_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid_i && !brk_i && dr_o && !take_i) |=> oe_o);

   // R8: a status read with no new loss clears overrun
   a_r8_oe_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd_i && !(rx_valid_i && dr_o && !take_i)) |=> !oe_o);

   // R9: break loads zero and raises both flags
   a_r9_break: assert property (@(posedge clk) disable iff (!rst_n)
      brk_i |=> (dr_o && bi_o && rbr_o == '0));

   // R6: a plain data read drops ready and break
   a_r6_take: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && !rx_valid_i && !brk_i) |=> (!dr_o && !bi_o));

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
   import uart_regfront_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int FIFO_FLAG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic [7:0]        tx_data,
   output logic              tx_valid,
   input  logic              tx_ready,
   input  logic [7:0]        rx_data,
   input  logic              rx_valid,
   input  logic              brk_inject,
   output logic              irq
);

   localparam int OFS_W = 3;
   localparam int DIV_W = 2 * BYTE_W;

   if (ADDR_W < OFS_W) begin : g_bad_addr
      $error("uart_regfront: ADDR_W must be at least 3");
   end
   if (FIFO_FLAG != 0 && FIFO_FLAG != 1) begin : g_bad_flag
      $error("uart_regfront: FIFO_FLAG must be 0 or 1");
   end

   if (ADDR_W > OFS_W) begin : g_hi_addr
      logic hi_unused;
      assign hi_unused = ^bus_addr[ADDR_W-1:OFS_W];
   end

   reg_ofs_e          ofs;
   logic              dlab;
   logic [BYTE_W-1:0] lcr_q, ier_q, mcr_q, msr_q, scr_q;
   logic [DIV_W-1:0]  div_q;
   logic [BYTE_W-1:0] rbr;
   logic              dr, bi, oe, thre;
   logic [BYTE_W-1:0] lsr, iid, iid_rd;
   logic              tx_load, take, lsr_rd;

   assign ofs  = reg_ofs_e'(bus_addr[OFS_W-1:0]);
   assign dlab = lcr_q[LC_DLAB];

   assign tx_load = bus_wr && ofs == OFS_DATA && !dlab;
   assign take    = bus_rd && ofs == OFS_DATA && !dlab;
   assign lsr_rd  = bus_rd && ofs == OFS_LSTAT;

   // software-visible storage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lcr_q <= '0;
         ier_q <= '0;
         mcr_q <= '0;
         msr_q <= '0;
         scr_q <= '0;
         div_q <= '0;
      end else if (bus_wr) begin
         unique case (ofs)
            OFS_DATA:    if (dlab) div_q[BYTE_W-1:0] <= bus_wdata;
            OFS_IEN:     if (dlab) div_q[DIV_W-1:BYTE_W] <= bus_wdata;
                         else      ier_q <= bus_wdata;
            OFS_LCTL:    lcr_q <= bus_wdata;
            OFS_MCTL:    mcr_q <= bus_wdata;
            OFS_MSTAT:   msr_q <= bus_wdata;
            OFS_SCRATCH: scr_q <= bus_wdata;
            default:     ;
         endcase
      end
   end

   uart_rf_txhold u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tx_load),
      .byte_i     (bus_wdata),
      .tx_data_o  (tx_data),
      .tx_valid_o (tx_valid),
      .tx_ready_i (tx_ready)
   );

   uart_rf_rxstat u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_valid_i (rx_valid),
      .rx_byte_i  (rx_data),
      .brk_i      (brk_inject),
      .take_i     (take),
      .lsr_rd_i   (lsr_rd),
      .rbr_o      (rbr),
      .dr_o       (dr),
      .bi_o       (bi),
      .oe_o       (oe)
   );

   assign thre = !tx_valid;

   always_comb begin
      lsr          = '0;
      lsr[ST_DR]   = dr;
      lsr[ST_OE]   = oe;
      lsr[ST_BI]   = bi;
      lsr[ST_THRE] = thre;
      lsr[ST_TEMT] = thre;
   end

   assign iid = pick_iid(dr && ier_q[IE_RX], thre && ier_q[IE_TX]);
   assign irq = (iid != ID_NONE);

   if (FIFO_FLAG == 1) begin : g_fifo_flag
      assign iid_rd = iid | ID_FIFO;
   end else begin : g_no_fifo_flag
      assign iid_rd = iid;
   end

   always_comb begin
      unique case (ofs)
         OFS_DATA:    bus_rdata = dlab ? div_q[BYTE_W-1:0] : rbr;
         OFS_IEN:     bus_rdata = dlab ? div_q[DIV_W-1:BYTE_W] : ier_q;
         OFS_IID:     bus_rdata = iid_rd;
         OFS_LCTL:    bus_rdata = lcr_q;
         OFS_MCTL:    bus_rdata = mcr_q;
         OFS_LSTAT:   bus_rdata = lsr;
         OFS_MSTAT:   bus_rdata = msr_q;
         default:     bus_rdata = scr_q;
      endcase
   end

   // R3: divisor-mode writes to offset 0 start nothing
   a_r3_dlab_no_tx: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && ofs == OFS_DATA && dlab && !tx_valid) |=> !tx_valid);

   // R5: both causes masked keeps the line quiet
   a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_q[IE_RX] == 1'b0 && ier_q[IE_TX] == 1'b0) |-> !irq);

   // R7: pending byte blocks the holding-empty cause
   a_r7_thre_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !dr) |-> !irq);

endmodule

// File: tb/uart_regfront_tb.sv
module uart_regfront_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] addr = '0;
   logic       wr = 1'b0, rd = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [7:0] tx_data;
   logic       tx_valid;
   logic       tx_ready = 1'b0;
   logic [7:0] rx_data = '0;
   logic       rx_valid = 1'b0;
   logic       brk = 1'b0;
   logic       irq;
   logic [7:0] ff_rdata, ff_txd;
   logic       ff_txv, ff_irq;

   always #2 clk = ~clk;

   uart_regfront #(.ADDR_W(8), .FIFO_FLAG(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
      .bus_wdata(wdata), .bus_rdata(rdata), .tx_data(tx_data), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
      .brk_inject(brk), .irq(irq));

   uart_regfront #(.ADDR_W(8), .FIFO_FLAG(1)) u_dut_ff (
      .clk(clk), .rst_n(rst_n), .bus_addr(8'h02), .bus_wr(1'b0), .bus_rd(1'b0),
      .bus_wdata(8'h00), .bus_rdata(ff_rdata), .tx_data(ff_txd), .tx_valid(ff_txv),
      .tx_ready(1'b0), .rx_data(8'h00), .rx_valid(1'b0),
      .brk_inject(1'b0), .irq(ff_irq));

   int total = 0;
   int bad = 0;
   bit finished = 0;

   // reference model
   logic [7:0]  m_lcr, m_ier, m_mcr, m_msr, m_scr, m_rbr, m_txb;
   logic [15:0] m_div;
   logic        m_dr, m_bi, m_oe, m_txp;

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] m_lsr();
      return {1'b0, !m_txp, !m_txp, m_bi, 2'b00, m_oe, m_dr};
   endfunction

   function automatic logic [7:0] m_iir();
      if (m_dr && m_ier[0]) return 8'h04;
      if (!m_txp && m_ier[1]) return 8'h02;
      return 8'h01;
   endfunction

   function automatic logic [7:0] m_rdval(input logic [7:0] a);
      logic dl = m_lcr[7];
      case (a[2:0])
         3'd0: return dl ? m_div[7:0] : m_rbr;
         3'd1: return dl ? m_div[15:8] : m_ier;
         3'd2: return m_iir();
         3'd3: return m_lcr;
         3'd4: return m_mcr;
         3'd5: return m_lsr();
         3'd6: return m_msr;
         default: return m_scr;
      endcase
   endfunction

   task automatic m_reset();
      m_lcr = 0; m_ier = 0; m_mcr = 0; m_msr = 0; m_scr = 0; m_rbr = 0; m_txb = 0;
      m_div = 0; m_dr = 0; m_bi = 0; m_oe = 0; m_txp = 0;
   endtask

   task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1'b1;
      @(posedge clk); #1 wr = 1'b0;
      case (a[2:0])
         3'd0: if (m_lcr[7]) m_div[7:0] = d;
               else if (!m_txp) begin m_txp = 1; m_txb = d; end
         3'd1: if (m_lcr[7]) m_div[15:8] = d; else m_ier = d;
         3'd3: m_lcr = d;
         3'd4: m_mcr = d;
         3'd6: m_msr = d;
         3'd7: m_scr = d;
         default: ;
      endcase
   endtask

   task automatic do_rd(input string tag, input logic [7:0] a);
      logic [7:0] got, exp;
      exp = m_rdval(a);
      @(negedge clk); addr = a; rd = 1'b1;
      #1 got = rdata;
      @(posedge clk); #1 rd = 1'b0;
      chk(tag, got, exp);
      if (a[2:0] == 3'd0 && !m_lcr[7]) begin m_dr = 0; m_bi = 0; end
      if (a[2:0] == 3'd5) m_oe = 0;
   endtask

   task automatic do_rx(input logic [7:0] d);
      @(negedge clk); rx_data = d; rx_valid = 1'b1;
      @(posedge clk); #1 rx_valid = 1'b0;
      if (m_dr) m_oe = 1;
      m_rbr = d; m_dr = 1;
   endtask

   task automatic do_brk();
      @(negedge clk); brk = 1'b1;
      @(posedge clk); #1 brk = 1'b0;
      m_rbr = 0; m_bi = 1; m_dr = 1;
   endtask

   task automatic do_accept();
      @(negedge clk); tx_ready = 1'b1;
      if (m_txp) chk("R7 accepted byte", tx_data, m_txb);
      @(posedge clk); #1 tx_ready = 1'b0;
      m_txp = 0;
   endtask

   task automatic check_outs(input string tag);
      @(negedge clk);
      chk({tag, " irq R5"}, {7'b0, irq}, {7'b0, m_iir() != 8'h01});
      chk({tag, " tx_valid R7"}, {7'b0, tx_valid}, {7'b0, m_txp});
      if (m_txp) chk({tag, " tx_data R7"}, tx_data, m_txb);
   endtask

   initial begin
      #(4 * 100000);
      if (!finished) begin
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240517));
      m_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R2: reset values at every offset
      for (int i = 0; i < 8; i++) do_rd("R2 reset value", 8'(i));
      check_outs("R2");

      // R10: build option sets bits 7:6 of the identification byte
      chk("R10 fifo flag iid", ff_rdata, 8'hC1);
      chk("R10 no flag iid", m_rdval(8'h02), 8'h01);

      // R1: upper address bits ignored
      do_wr(8'hF7, 8'h5A);
      do_rd("R1 scratch alias", 8'h07);
      do_rd("R1 scratch high alias", 8'h2F);

      // R11: stores and read-only offsets
      do_wr(8'h04, 8'h1F); do_wr(8'h06, 8'hA5);
      do_wr(8'h02, 8'hFF); do_wr(8'h05, 8'hFF);
      do_rd("R11 mcr", 8'h04); do_rd("R11 msr", 8'h06);
      do_rd("R11 iid after write", 8'h02); do_rd("R11 lsr after write", 8'h05);

      // R3: divisor latch
      do_wr(8'h01, 8'h03);
      do_wr(8'h03, 8'h83);
      do_wr(8'h00, 8'h34); do_wr(8'h01, 8'h12);
      check_outs("R3 no tx");
      do_rd("R3 div low", 8'h00); do_rd("R3 div high", 8'h01);
      do_wr(8'h03, 8'h03);
      do_rd("R3 ier kept", 8'h01);
      do_wr(8'h03, 8'h80);
      do_rd("R3 div high survives", 8'h01);
      do_wr(8'h03, 8'h00);

      // R4 / R5: priority (ier = 0x03, holding empty)
      do_rd("R4 tx cause", 8'h02);
      do_rx(8'h77);
      do_rd("R4 rx first", 8'h02);
      check_outs("R4");
      do_rd("R6 data read", 8'h00);
      do_rd("R6 lsr after read", 8'h05);
      do_wr(8'h01, 8'h00);
      check_outs("R5 masked");
      do_rd("R4 none", 8'h02);

      // R7: transmit hold and drop
      do_wr(8'h00, 8'hC3);
      check_outs("R7 load");
      do_rd("R7 lsr pending", 8'h05);
      do_wr(8'h00, 8'h11);
      repeat (3) check_outs("R7 hold");
      do_accept();
      check_outs("R7 released");
      do_rd("R7 lsr empty", 8'h05);

      // R8: overrun, clear on status read, read coincident with strobe
      do_rx(8'h01); do_rx(8'h02);
      do_rd("R8 lsr overrun", 8'h05);
      do_rd("R8 lsr cleared", 8'h05);
      begin
         logic [7:0] got;
         @(negedge clk); addr = 8'h00; rd = 1'b1; rx_data = 8'h55; rx_valid = 1'b1;
         #1 got = rdata;
         @(posedge clk); #1 begin rd = 1'b0; rx_valid = 1'b0; end
         chk("R8 read with strobe data", got, m_rbr);
         m_rbr = 8'h55; m_dr = 1; m_bi = 0;
      end
      do_rd("R8 lsr ready kept", 8'h05);
      do_rd("R6 drain", 8'h00);

      // R9: break
      do_wr(8'h01, 8'h01);
      do_brk();
      check_outs("R9");
      do_rd("R9 lsr", 8'h05);
      do_rd("R9 rbr zero", 8'h00);
      do_rd("R9 lsr cleared", 8'h05);

      // random mix
      for (int n = 0; n < 800; n++) begin
         int k = $urandom % 6;
         logic [7:0] a = 8'($urandom);
         logic [7:0] d = 8'($urandom);
         case (k)
            0: do_wr(a, d);
            1: do_rd("R11 R6 R8 random read", a);
            2: do_rx(d);
            3: if (($urandom % 4) == 0) do_brk();
            4: do_accept();
            default: ;
         endcase
         check_outs("R5 random");
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule